// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Edge Capture

This block is a general-purpose I/O port of up to 32 pins. A host reaches it through a simple bus that carries a word address, a write strobe and a read strobe. Each pin can be set as an input or an output. The block drives an output value and an output-enable per pin toward the pad ring. It also returns the synchronised pin levels on reads.

A per-pin enable register and a sticky edge register combine into one interrupt line toward the host. The trigger kind is fixed at build time by the parameter `TRIGGER`, and software cannot change it. The kinds are rising edge, falling edge, either edge, and level high.

In the three edge kinds, a detected edge sets a sticky bit that stays set until the host writes a one to it. In level-high kind, the interrupt follows the enabled pin levels directly and nothing is latched. Pin inputs pass through a two-flop synchroniser before they are read back or used for detection.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `pin_out` is 0, the enable and sticky-edge registers read 0, and `irq` is 0.
- R2: Word address 1 (byte offset 0x4) is the direction register. A bit value of 1 sets that pin's `pin_oe` high (output) and 0 sets it low (input). The register reads back as written.
- R3: A write to word address 0 (byte offset 0x0) sets `pin_out`. A read of word address 0 returns the pin levels after the two-flop synchroniser. `bus_rdata` is registered and is valid in the cycle after the read strobe.
- R4: Word address 2 (byte offset 0x8) is the interrupt-enable register. A bit value of 1 enables that pin and 0 disables it. The register reads back as written.
- R5: Word address 3 (byte offset 0xC) is the sticky-edge register. The bit for a pin is set when the synchronised level goes 0 to 1 in rising kind, 1 to 0 in falling kind, and either way in both-edge kind. In level-high kind it always reads 0.
- R6: Writing a 1 to a sticky-edge bit clears it. Writing a 0 leaves it unchanged. A read does not alter it.
- R7: If an edge is detected on a pin in the same cycle that the host clears that pin's sticky bit, the bit ends up set.
- R8: In the edge kinds, `irq` is high exactly when some pin has both its sticky bit and its enable bit set.
- R9: In level-high kind, `irq` is high exactly when some enabled pin's synchronised level is 1. It drops as soon as the level falls and is never latched.
- R10: Write-data bits at and above `PIN_COUNT` are ignored, and those bit positions always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 data, 1 direction, 2 enable, 3 sticky edge |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Levels sampled from the pads |
| pin_out | output | PIN_COUNT | Output values toward the pads |
| pin_oe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Interrupt request toward the host |

## Verification
The checker asserts these rules on every cycle:
- A direction write shows up on `pin_oe` in the next cycle.
- A sticky bit cleared by a one stays clear unless an edge arrived in the same cycle.
- Sticky bits never drop without a clear.
- A coincident edge always leaves its bit set.
- `irq` always equals the enabled-and-captured reduction, or the enabled-level reduction in level kind.

Some behaviour only the bench's scenarios can show, because it depends on stimulus at the pins:
- the synchroniser latency;
- which transitions each trigger kind treats as an edge;
- that level interrupts drop without a clear.

To cover these, the bench sweeps every from/to pair of pin patterns through four instances, one per trigger kind.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Build-time choice of what raises the interrupt
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_mode_e;

    // Word-address selection of the four registers
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_CAP  = 2'd3
    } reg_sel_e;

    localparam int unsigned BUS_W = 32;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    // Two flops per pin; each bit is an independent crossing
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic stage1_q;
        logic stage2_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= raw_in[i];
                stage2_q <= stage1_q;
            end
        end

        assign sync_out[i] = stage2_q;
    end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH   = 8,
    parameter trig_mode_e  TRIGGER = TRIG_BOTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] event_o
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= level;
        end
    end

    assign rise = level & ~prev_q;
    assign fall = prev_q & ~level;

    always_comb begin
        unique case (TRIGGER)
            TRIG_RISE:  event_o = rise;
            TRIG_FALL:  event_o = fall;
            TRIG_BOTH:  event_o = rise | fall;
            default:    event_o = '0;
        endcase
    end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             rd,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pin_lvl,
    input  logic [WIDTH-1:0] edge_evt,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] cap_q,
    output logic [WIDTH-1:0] rdata_q
);

    logic [WIDTH-1:0] clr_bits;
    logic [WIDTH-1:0] rd_mux;

    assign clr_bits = (wr && sel == SEL_CAP) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_DATA: out_q  <= wdata;
                SEL_DIR:  dir_q  <= wdata;
                SEL_MASK: mask_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Clear first, then set: a coincident edge keeps the bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= (cap_q & ~clr_bits) | edge_evt;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rd_mux = pin_lvl;
            SEL_DIR:  rd_mux = dir_q;
            SEL_MASK: rd_mux = mask_q;
            default:  rd_mux = cap_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= rd_mux;
        end
    end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 8,
    parameter trig_mode_e  TRIGGER   = TRIG_BOTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    localparam int unsigned PAD_W = BUS_W - PIN_COUNT;

    logic [PIN_COUNT-1:0] pin_lvl;
    logic [PIN_COUNT-1:0] edge_evt;
    logic [PIN_COUNT-1:0] dir_q;
    logic [PIN_COUNT-1:0] mask_q;
    logic [PIN_COUNT-1:0] cap_q;
    logic [PIN_COUNT-1:0] rdata_q;
    logic                 unused_wdata;
    reg_sel_e             sel;

    assign sel          = reg_sel_e'(bus_addr);
    assign unused_wdata = ^bus_wdata;

    gpio_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_lvl)
    );

    gpio_edge_detect #(.WIDTH(PIN_COUNT), .TRIGGER(TRIGGER)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (pin_lvl),
        .event_o (edge_evt)
    );

    gpio_regs #(.WIDTH(PIN_COUNT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .sel      (sel),
        .wdata    (bus_wdata[PIN_COUNT-1:0]),
        .pin_lvl  (pin_lvl),
        .edge_evt (edge_evt),
        .out_q    (pin_out),
        .dir_q    (dir_q),
        .mask_q   (mask_q),
        .cap_q    (cap_q),
        .rdata_q  (rdata_q)
    );

    assign pin_oe = dir_q;

    if (PAD_W > 0) begin : g_pad
        assign bus_rdata = {{PAD_W{1'b0}}, rdata_q};
    end else begin : g_full
        assign bus_rdata = rdata_q;
    end

    if (TRIGGER == TRIG_LEVEL) begin : g_irq_level
        assign irq = |(pin_lvl & mask_q);
    end else begin : g_irq_edge
        assign irq = |(cap_q & mask_q);
    end

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_pkg::*;
#(
    parameter int unsigned PIN_COUNT = 8,
    parameter trig_mode_e  TRIGGER   = TRIG_BOTH
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           bus_addr,
    input logic                 bus_wr,
    input logic [31:0]          bus_wdata,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic [PIN_COUNT-1:0] pin_lvl,
    input logic [PIN_COUNT-1:0] cap_q,
    input logic [PIN_COUNT-1:0] mask_q,
    input logic [PIN_COUNT-1:0] edge_evt,
    input logic                 irq
);

    logic [PIN_COUNT-1:0] clr_req;
    logic                 dir_wr;

    assign clr_req = (bus_wr && bus_addr == 2'd3) ? bus_wdata[PIN_COUNT-1:0] : '0;
    assign dir_wr  = bus_wr && bus_addr == 2'd1;

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> pin_oe == $past(bus_wdata[PIN_COUNT-1:0])); // R2

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req != '0) |=> (cap_q & $past(clr_req & ~edge_evt)) == '0); // R6

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cap_q & $past(cap_q & ~clr_req)) == $past(cap_q & ~clr_req)); // R6

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cap_q & $past(edge_evt)) == $past(edge_evt)); // R7

    if (TRIGGER == TRIG_LEVEL) begin : g_level
        AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            irq == |(pin_lvl & mask_q)); // R9
        AST_LEVEL_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            cap_q == '0); // R5
    end else begin : g_edge
        AST_EDGE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
            irq == |(cap_q & mask_q)); // R8
    end

endmodule

bind gpio_edge_port gpio_edge_port_chk #(
    .PIN_COUNT (PIN_COUNT),
    .TRIGGER   (TRIGGER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .pin_lvl   (pin_lvl),
    .cap_q     (cap_q),
    .mask_q    (mask_q),
    .edge_evt  (edge_evt),
    .irq       (irq)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
    import gpio_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [NP-1:0] pins = '0;

    logic [31:0]   rd_b, rd_r, rd_f, rd_l;
    logic [NP-1:0] out_b, out_r, out_f, out_l;
    logic [NP-1:0] oe_b, oe_r, oe_f, oe_l;
    logic          irq_b, irq_r, irq_f, irq_l;

    logic [31:0] v_b, v_r, v_f, v_l;
    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_port #(.PIN_COUNT(NP), .TRIGGER(TRIG_BOTH)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_b), .pin_in(pins), .pin_out(out_b),
        .pin_oe(oe_b), .irq(irq_b));
    gpio_edge_port #(.PIN_COUNT(NP), .TRIGGER(TRIG_RISE)) uut_rise (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_r), .pin_in(pins), .pin_out(out_r),
        .pin_oe(oe_r), .irq(irq_r));
    gpio_edge_port #(.PIN_COUNT(NP), .TRIGGER(TRIG_FALL)) uut_fall (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_f), .pin_in(pins), .pin_out(out_f),
        .pin_oe(oe_f), .irq(irq_f));
    gpio_edge_port #(.PIN_COUNT(NP), .TRIGGER(TRIG_LEVEL)) uut_lvl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(rd_l), .pin_in(pins), .pin_out(out_l),
        .pin_oe(oe_l), .irq(irq_l));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        v_b = rd_b; v_r = rd_r; v_f = rd_f; v_l = rd_l;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin : watchdog
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        finish_run();
    end

    initial begin : main
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        check("R1 oe", {28'd0, oe_b}, 32'd0);
        check("R1 out", {28'd0, out_b}, 32'd0);
        check("R1 irq", {28'd0, irq_b, irq_r, irq_f, irq_l}, 32'd0);
        bus_read(2'd2); check("R1 mask", v_b, 32'd0);
        bus_read(2'd3); check("R1 cap", v_b, 32'd0);
        bus_read(2'd1); check("R1 dir", v_b, 32'd0);

        // R2, R3, R10: direction and output sweep, upper bits ignored
        for (int v = 0; v < 16; v++) begin
            bus_write(2'd1, 32'hFFFF_FFF0 | v);
            check("R2 pin_oe", {28'd0, oe_b}, v);
            bus_read(2'd1);
            check("R10 dir readback", v_b, v);
            bus_write(2'd0, 32'hA5A5_A5A0 | (15 - v));
            check("R3 pin_out", {28'd0, out_l}, 15 - v);
        end

        // R3 pin level readback through the synchroniser
        for (int p = 0; p < 16; p++) begin
            pins = p[NP-1:0];
            settle(3);
            bus_read(2'd0);
            check("R3 data read", v_b, p);
        end

        // R4 enable register readback
        for (int m = 0; m < 16; m++) begin
            bus_write(2'd2, 32'h1234_5670 | m);
            bus_read(2'd2);
            check("R4 mask readback", v_r, m);
        end

        // R5, R8, R9: every from/to pin pair, all pins enabled
        bus_write(2'd2, 32'hF);
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [3:0] fa, tb2;
                fa = a[3:0]; tb2 = b[3:0];
                pins = fa;
                settle(4);
                bus_write(2'd3, 32'hF);
                pins = tb2;
                settle(3);
                check("R8 irq both", {31'd0, irq_b}, {31'd0, |(fa ^ tb2)});
                check("R8 irq rise", {31'd0, irq_r}, {31'd0, |(tb2 & ~fa)});
                check("R8 irq fall", {31'd0, irq_f}, {31'd0, |(fa & ~tb2)});
                check("R9 irq level", {31'd0, irq_l}, {31'd0, |tb2});
                bus_read(2'd3);
                check("R5 cap both", v_b, {28'd0, fa ^ tb2});
                check("R5 cap rise", v_r, {28'd0, tb2 & ~fa});
                check("R5 cap fall", v_f, {28'd0, fa & ~tb2});
                check("R5 cap level", v_l, 32'd0);
            end
        end

        // R8 enable gating and R6 clear semantics
        pins = 4'h0; settle(4);
        bus_write(2'd3, 32'hF);
        bus_write(2'd2, 32'h0);
        pins = 4'hF; settle(4);
        check("R8 masked irq", {31'd0, irq_r}, 32'd0);
        bus_read(2'd3);
        check("R6 read keeps cap", v_r, 32'hF);
        bus_read(2'd3);
        check("R6 second read", v_r, 32'hF);
        bus_write(2'd2, 32'h2);
        check("R8 one enabled", {31'd0, irq_r}, 32'd1);
        bus_write(2'd3, 32'h2);
        check("R8 irq after clear", {31'd0, irq_r}, 32'd0);
        bus_read(2'd3);
        check("R6 w1c", v_r, 32'hD);
        bus_write(2'd3, 32'h0);
        bus_read(2'd3);
        check("R6 write zero", v_r, 32'hD);

        // R9 no latching in level kind
        bus_write(2'd2, 32'h4);
        pins = 4'h4; settle(3);
        check("R9 level high", {31'd0, irq_l}, 32'd1);
        pins = 4'h0; settle(3);
        check("R9 level drop", {31'd0, irq_l}, 32'd0);

        // R7 edge coincident with clear
        bus_write(2'd2, 32'h0);
        pins = 4'h0; settle(4);
        bus_write(2'd3, 32'hF);
        pins = 4'h1; settle(4);
        pins = 4'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_addr = 2'd3; bus_wdata = 32'h1; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_read(2'd3);
        check("R7 both edge wins", v_b, 32'h1);
        check("R7 rise cleared", v_r, 32'h0);
        check("R7 fall edge wins", v_f, 32'h1);

        finish_run();
    end

endmodule